// File: doc/BRIEF.md
# Programmable sum-of-products array

This block is a small field-configurable logic array. Eight user inputs and four feedback values each enter a programmable AND plane in both true and inverted form. Every product term picks any subset of those twenty-four literals through its own configuration mask. A fixed OR plane gives each output its own private group of product terms, and the groups differ in size. Each OR result then enters an output cell. That cell chooses whether the pin shows the OR result directly or the value its flip-flop captured at the last clock edge, and whether that value is inverted.

Every output cell's flip-flop drives a feedback literal into the AND plane. Small state machines can therefore be built without any outside wiring. The whole configuration is a single serial chain, loaded one bit per clock while the load enable is high. During loading the array is kept silent: all pins read 0 and every cell's flip-flop is held at 0.

Top module: `pla_array`

## Requirements
- R1: Each product term has a 24-bit mask covering 12 literals. Literal k (0..7) is `data_in[k]` and literal k (8..11) is the flip-flop of output cell k-8. Mask bit 2k requires the literal to be 1, and mask bit 2k+1 requires it to be 0. A term is 1 only when every requirement it sets holds.
- R2: A term whose mask sets both bits of any one literal is always 0.
- R3: A term whose mask is all zero is always 1.
- R4: The OR plane is fixed. Outputs 0, 1, 2 and 3 sum 8, 10, 12 and 16 product terms. The terms are numbered globally from 0 to 45 in output order, so output 0 owns terms 0..7, output 1 owns 8..17, output 2 owns 18..29 and output 3 owns 30..45.
- R5: With configuration bit 2o clear, output o is combinational: `data_out[o]` follows its OR result in the same cycle.
- R6: With configuration bit 2o set, output o is registered: `data_out[o]` shows the OR result captured at the previous rising clock edge.
- R7: With configuration bit 2o+1 set, output o is inverted after the registered/combinational choice.
- R8: Each output cell's flip-flop captures its OR result (before inversion) on every rising edge, whatever its mode. Its value is the feedback literal seen by every term.
- R9: While `cfg_en` is high, one bit of `cfg_din` enters the 1112-bit configuration chain per rising edge. The bit shifted in first ends at the highest index. Bits 0..7 are the output-cell bits (R5 to R7). Global term g uses bits 8+24g to 31+24g. While `cfg_en` is low the chain keeps its contents and ignores `cfg_din`.
- R10: While `cfg_en` is high, `data_out` is 0, and each output-cell flip-flop is 0 at the following edge.
- R11: Reset is synchronous and active low. It clears the configuration chain and all flip-flops, so afterwards every output is combinational, non-inverted and reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration load enable; silences the array |
| cfg_din | input | 1 | Serial configuration bit |
| data_in | input | 8 | User inputs |
| data_out | output | 4 | User outputs |

## Verification
The bench first loads a hand-built pattern: a toggle cell fed back on itself, an inverted NOR, and the very last term of the widest output gated by another output's flip-flop. If the term groups were sliced at the wrong offset, or the feedback were taken after inversion, this pattern would show a misplaced or wrong value within a few cycles. Random sparse configurations then run with `cfg_din` toggling while the load enable is low. A chain that shifted when it should not would corrupt the function, and a missing conflict or empty-term rule would flip terms that the model keeps at 0 or 1. A reset in mid-run must restore the all-ones state, which a design that kept its configuration across reset would miss.

// File: rtl/pla_pkg.sv
// Package: sizing helpers shared by the array and its bench-facing top.
// Assumes all outputs but the last get PT_BASE + PT_STEP*o terms; the last gets PT_LAST.
package pla_pkg;

    // Number of product terms owned by output o.
    function automatic int pt_count(input int o, input int n_out,
                                    input int base, input int step, input int last);
        return (o == n_out - 1) ? last : base + step * o;
    endfunction

    // Global index of the first product term of output o.
    function automatic int pt_offset(input int o, input int n_out,
                                     input int base, input int step, input int last);
        int acc;
        acc = 0;
        for (int i = 0; i < o; i++) acc += pt_count(i, n_out, base, step, last);
        return acc;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
// Serial configuration store: shifts one bit in per clock while enabled.
// Assumes the first bit shifted in is meant for the highest index.
module pla_cfg_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);

    // Shift register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end

    a_r9_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && $past(rst_n)) |=> $stable(q))
        else $error("R9: chain changed while not loading");

endmodule

// File: rtl/pla_term.sv
// One AND-plane product term over true/complement literals.
// Assumes mask bit 2k demands literal k high and bit 2k+1 demands it low.
module pla_term #(
    parameter int N_LIT = 12,
    localparam int MW   = 2 * N_LIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mask,
    input  logic [N_LIT-1:0] lits,
    output logic             hit
);

    logic [N_LIT-1:0] need_hi;
    logic [N_LIT-1:0] need_lo;

    // Split the mask into its true and complement halves.
    always_comb begin
        for (int k = 0; k < N_LIT; k++) begin
            need_hi[k] = mask[2*k];
            need_lo[k] = mask[2*k+1];
        end
    end

    // AND of every literal the mask connects.
    always_comb begin
        hit = 1'b1;
        for (int k = 0; k < N_LIT; k++) begin
            if (mask[2*k]   && !lits[k]) hit = 1'b0;
            if (mask[2*k+1] &&  lits[k]) hit = 1'b0;
        end
    end

    a_r3_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> hit)
        else $error("R3: empty term not 1");

    a_r2_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (|(need_hi & need_lo)) |-> !hit)
        else $error("R2: conflicting term not 0");

endmodule

// File: rtl/pla_or_group.sv
// Fixed OR of the product terms owned by one output.
// Assumes the masks arrive packed with term 0 in the low bits.
module pla_or_group #(
    parameter int N_LIT = 12,
    parameter int N_PT  = 8,
    localparam int MW   = 2 * N_LIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PT*MW-1:0] masks,
    input  logic [N_LIT-1:0]   lits,
    output logic               sum
);

    logic [N_PT-1:0] hits;

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        pla_term #(.N_LIT(N_LIT)) u_term (
            .clk   (clk),
            .rst_n (rst_n),
            .mask  (masks[t*MW +: MW]),
            .lits  (lits),
            .hit   (hits[t])
        );
    end

    // Fixed OR plane for this output.
    always_comb sum = |hits;

endmodule

// File: rtl/pla_macrocell.sv
// Output cell: flip-flop, registered/combinational select, polarity, load gating.
// Assumes hold is the configuration-load enable; the flip-flop feeds back uninverted.
module pla_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic reg_mode,
    input  logic invert,
    input  logic sum,
    output logic q,
    output logic pin
);

    // Capture the OR result each edge; cleared by reset and by loading.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (hold) q <= 1'b0;
        else           q <= sum;
    end

    // Pick the path, apply polarity, silence during loading.
    always_comb pin = hold ? 1'b0 : ((reg_mode ? q : sum) ^ invert);

    a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (q == 1'b0))
        else $error("R10: flip-flop not held at 0 while loading");

    a_r6_reg_path: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hold) && !hold && reg_mode)
            |-> (pin == ($past(sum) ^ invert)))
        else $error("R6: registered output not last edge's sum");

endmodule

// File: rtl/pla_array.sv
// Top: configurable AND-OR array with unequal term groups and feedback cells.
// Assumes config layout: cell bits at the bottom, then term masks in output order.
module pla_array #(
    parameter int N_IN    = 8,
    parameter int N_OUT   = 4,
    parameter int PT_BASE = 8,
    parameter int PT_STEP = 2,
    parameter int PT_LAST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  data_in,
    output logic [N_OUT-1:0] data_out
);
    import pla_pkg::*;

    localparam int N_LIT   = N_IN + N_OUT;
    localparam int MASK_W  = 2 * N_LIT;
    localparam int MC_BITS = 2 * N_OUT;
    localparam int N_PT    = pt_offset(N_OUT, N_OUT, PT_BASE, PT_STEP, PT_LAST);
    localparam int CFG_W   = MC_BITS + N_PT * MASK_W;

    logic [CFG_W-1:0] cfg_q;
    logic [N_OUT-1:0] fb_q;
    logic [N_OUT-1:0] or_sum;
    logic [N_LIT-1:0] lits;

    pla_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .q        (cfg_q)
    );

    // Literal vector: user inputs low, feedback high.
    always_comb lits = {fb_q, data_in};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int CNT = pt_count(o, N_OUT, PT_BASE, PT_STEP, PT_LAST);
        localparam int OFS = pt_offset(o, N_OUT, PT_BASE, PT_STEP, PT_LAST);

        pla_or_group #(.N_LIT(N_LIT), .N_PT(CNT)) u_or (
            .clk   (clk),
            .rst_n (rst_n),
            .masks (cfg_q[MC_BITS + OFS*MASK_W +: CNT*MASK_W]),
            .lits  (lits),
            .sum   (or_sum[o])
        );

        pla_macrocell u_mc (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (cfg_en),
            .reg_mode (cfg_q[2*o]),
            .invert   (cfg_q[2*o+1]),
            .sum      (or_sum[o]),
            .q        (fb_q[o]),
            .pin      (data_out[o])
        );
    end

    a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (data_out == '0))
        else $error("R10: outputs active while loading");

    a_r11_reset_state: assert property (@(posedge clk)
        (!rst_n && !cfg_en) |=> (rst_n && !cfg_en) |-> (data_out == '1))
        else $error("R11: outputs not all 1 after reset");

endmodule

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb_top;

    localparam int CFG_W = 8 + 46 * 24;
    localparam int NLIT  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [3:0] data_out;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    string phase = "R11";

    // Reference state
    logic [CFG_W-1:0] cfg_m = '0;
    logic [3:0]       q_m = 4'h0;
    logic [CFG_W-1:0] tgt;

    pla_array dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .data_in  (data_in),
        .data_out (data_out)
    );

    always #4 clk = ~clk;

    function automatic int first_term(input int o);
        int c[4] = '{8, 10, 12, 16};
        int acc = 0;
        for (int i = 0; i < o; i++) acc += c[i];
        return acc;
    endfunction

    function automatic int n_terms(input int o);
        int c[4] = '{8, 10, 12, 16};
        return c[o];
    endfunction

    // OR results of the reference model for given inputs and flip-flops.
    function automatic logic [3:0] model_sum(input logic [7:0] din, input logic [3:0] ff);
        logic [3:0] s = 4'h0;
        for (int o = 0; o < 4; o++) begin
            for (int t = 0; t < n_terms(o); t++) begin
                int base = 8 + 24 * (first_term(o) + t);
                logic term = 1'b1;
                for (int k = 0; k < NLIT; k++) begin
                    logic v = (k < 8) ? din[k] : ff[k-8];
                    if (cfg_m[base + 2*k]     == 1'b1 && v == 1'b0) term = 1'b0;
                    if (cfg_m[base + 2*k + 1] == 1'b1 && v == 1'b1) term = 1'b0;
                end
                if (term) s[o] = 1'b1;
            end
        end
        return s;
    endfunction

    function automatic logic [3:0] model_out();
        logic [3:0] s = model_sum(data_in, q_m);
        logic [3:0] r;
        if (cfg_en) return 4'h0;
        for (int o = 0; o < 4; o++)
            r[o] = (cfg_m[2*o] ? q_m[o] : s[o]) ^ cfg_m[2*o+1];
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: data_out=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    // Model update at each edge, then compare once outputs settle.
    always @(posedge clk) begin
        logic [3:0] s;
        s = model_sum(data_in, q_m);
        if (!rst_n) begin
            cfg_m = '0;
            q_m   = 4'h0;
        end else if (cfg_en) begin
            cfg_m = {cfg_m[CFG_W-2:0], cfg_din};
            q_m   = 4'h0;
        end else begin
            q_m = s;
        end
        #2;
        if (chk_on) check(phase, data_out, model_out());
    end

    // Build helpers for directed configurations.
    task automatic kill_all();
        tgt = '0;
        for (int g = 0; g < 46; g++) begin
            tgt[8 + 24*g]     = 1'b1;
            tgt[8 + 24*g + 1] = 1'b1;
        end
    endtask

    task automatic clear_term(input int g);
        for (int b = 0; b < 24; b++) tgt[8 + 24*g + b] = 1'b0;
    endtask

    task automatic set_lit(input int g, input int k, input bit low);
        tgt[8 + 24*g + 2*k + (low ? 1 : 0)] = 1'b1;
    endtask

    task automatic load_cfg();
        for (int i = CFG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = tgt[i];
            data_in = 8'($urandom);
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic run_random(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            data_in = 8'($urandom);
            cfg_din = 1'($urandom);
        end
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset clears configuration, outputs read 1.
        repeat (4) @(negedge clk);
        chk_on = 1'b1;
        rst_n = 1'b1;
        @(posedge clk); #3;
        check("R11", data_out, 4'hF);

        // Directed pattern: R1 R4 R5 R6 R7 R8
        kill_all();
        tgt[1:0] = 2'b00;              // out0 comb, true
        tgt[3:2] = 2'b01;              // out1 registered, true
        tgt[5:4] = 2'b10;              // out2 comb, inverted
        tgt[7:6] = 2'b11;              // out3 registered, inverted
        clear_term(0);  set_lit(0, 0, 0);  set_lit(0, 1, 1);   // in0 & ~in1
        clear_term(17); set_lit(17, 9, 1);                     // ~fb1 toggle, last term of out1
        clear_term(18); set_lit(18, 2, 0);                     // in2
        clear_term(19); set_lit(19, 3, 0);                     // in3
        clear_term(45); set_lit(45, 7, 0); set_lit(45, 8, 0);  // in7 & fb0, last term of out3
        phase = "R9/R10";
        load_cfg();
        data_in = 8'h01;
        phase = "R5/R6/R7/R8";
        @(posedge clk); #3;
        check("R6 R7 R8 first edge", data_out, 4'hF);
        @(posedge clk); #3;
        check("R6 toggle R5 comb", data_out, 4'hD);
        @(negedge clk);
        data_in = 8'h81;
        @(posedge clk); #3;
        check("R8 feedback R4 last term", data_out, 4'h7);
        @(negedge clk);
        data_in = 8'h04;
        #1;
        check("R7 inverted NOR R5", data_out[2:0], 3'b010);
        phase = "R1/R4";
        run_random(200);

        // Random sparse configurations: R1 R2 R3 R4 R9
        for (int n = 0; n < 3; n++) begin
            for (int b = 0; b < CFG_W; b++) tgt[b] = ($urandom_range(0, 9) == 0);
            tgt[7:0] = 8'($urandom);
            if (n == 0) clear_term(3);               // R3 empty term
            if (n == 1) begin                        // R2 conflict
                clear_term(30); set_lit(30, 5, 0); set_lit(30, 5, 1);
            end
            phase = "R9/R10";
            load_cfg();
            phase = "R1/R2/R3/R9";
            run_random(300);
        end

        // R11: reset mid-run restores the cleared state.
        @(negedge clk);
        rst_n = 1'b0;
        phase = "R11";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #3;
        check("R11 mid-run", data_out, 4'hF);
        run_random(20);

        chk_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule